// File: doc/BRIEF.md
# Signalling Voltage Switch Sequencer

This block moves the I/O signalling level of an SD card slot between 3.3 V and 1.8 V. A single-cycle request gives the wanted level and the highest voltage the slot can supply. The block first checks that the slot can reach the target at all. It then gates the card clock and updates the 1.8 V select bit of the host control image. Next it asks an external regulator for the new rail range through a request/acknowledge handshake and waits for the rail to settle. Finally it restores the card clock, and for a 1.8 V target it writes new values into the pad auto-calibration word and the pad reference word.

If the regulator reports a failure, the block falls back to the 3.3 V range, turns the clock back on and ends with an error. A slot that has no regulator is described by a tie-off input, and the handshake is then skipped. The two settle times, 10 ms and 1 ms, are derived from the clock frequency parameter.

Top module: `vsw_seq`

## Requirements
- R1: A 1.8 V request (`req_to_1v8_i`=1) requests the range 1800–1800 mV and writes `sel_1v8_o`=1. A 3.3 V request requests 2700–3600 mV and writes `sel_1v8_o`=0.
- R2: When the target minimum (1800 or 2700 mV) exceeds `slot_max_mv_i`, `done_o` pulses with `err_o`=0 on the clock edge that accepts the request. Clock enable, select bit, regulator request and calibration outputs all stay as they were.
- R3: `card_clk_en_o` falls on the accepting edge, which is at least one cycle before the select bit changes. It stays low for as long as `reg_req_o` is high.
- R4: `reg_req_o` holds high until `reg_ack_i` is seen. With `reg_absent_i`=1 the sequence never raises `reg_req_o` and starts the long wait two edges after acceptance.
- R5: An acknowledge that carries `reg_fail_i`=1 leads to one more request for 2700–3600 mV. The clock is re-enabled on that request's acknowledge edge. `done_o` follows after the short wait with `err_o`=1, and no calibration write is made.
- R6: After a good acknowledge the clock enable returns exactly LONG cycles later (10 ms of clock). The sequence then ends SHORT cycles (1 ms) after that, plus one cycle when calibration is written.
- R7: For a successful 1.8 V switch, `cal_we_o` pulses once, SHORT cycles after the clock returns and one cycle before `done_o`. `cal_wdata_o` equals `cal_cur_i` with bit 29 set, bits 14:8 = 0x70 and bits 6:0 = 0x62; all other bits are kept.
- R8: With the same pulse, `pad_wdata_o` equals `pad_cur_i` with bits 3:0 = 7 and every other bit kept.
- R9: A request that arrives while a sequence is running has no effect. The running sequence ends with its own target and a single `done_o`.
- R10: `done_o` is a one-cycle pulse, and `err_o` is high only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle switch request |
| req_to_1v8_i | input | 1 | Target level: 1 = 1.8 V, 0 = 3.3 V |
| slot_max_mv_i | input | MV_W | Highest voltage the slot supports, in mV |
| reg_absent_i | input | 1 | Tie-off: the slot has no regulator, so the handshake is skipped |
| reg_ack_i | input | 1 | Regulator acknowledge |
| reg_fail_i | input | 1 | Regulator failure, valid with the acknowledge |
| cal_cur_i | input | 32 | Current pad auto-calibration word |
| pad_cur_i | input | 32 | Current pad control word |
| card_clk_en_o | output | 1 | Card clock enable |
| sel_1v8_o | output | 1 | 1.8 V select bit of the host control image |
| reg_req_o | output | 1 | Regulator request |
| reg_min_mv_o | output | MV_W | Requested minimum, in mV |
| reg_max_mv_o | output | MV_W | Requested maximum, in mV |
| cal_we_o | output | 1 | Write strobe for both calibration words |
| cal_wdata_o | output | 32 | New auto-calibration word |
| pad_wdata_o | output | 32 | New pad control word |
| done_o | output | 1 | Sequence finished |
| err_o | output | 1 | Sequence finished after a regulator failure |

## Verification
The assertions check ordering properties on every cycle. The clock enable is always low before the select bit moves and for the whole time a rail request is open. A request stays up until it is acknowledged. The countdown steps by one. A calibration write is always followed by a clean done, and done never lasts longer than one cycle. Other properties can only be shown by the bench's sweep over target, slot limit, regulator presence and failure: the exact LONG and SHORT wait lengths, the requested ranges, the fallback request, the preserved bits of the calibration words, the skip path, and that a request made during a running sequence is dropped.

// File: rtl/vsw_pkg.sv
package vsw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GATE,
        ST_RAIL,
        ST_ACK,
        ST_FB_REQ,
        ST_FB_ACK,
        ST_WLONG,
        ST_WSHORT,
        ST_CAL
    } vsw_state_e;

    // rail ranges in millivolts
    localparam int LOW_MIN_MV  = 1800;
    localparam int LOW_MAX_MV  = 1800;
    localparam int HIGH_MIN_MV = 2700;
    localparam int HIGH_MAX_MV = 3600;

    // calibration word layout
    localparam int        CAL_EN_BIT = 29;
    localparam int        OFS_W      = 7;
    localparam int        PD_LSB     = 8;
    localparam int        PU_LSB     = 0;
    localparam logic [6:0] PD_OFS    = 7'h70;
    localparam logic [6:0] PU_OFS    = 7'h62;

    // pad control layout
    localparam int        REF_W      = 4;
    localparam logic [3:0] REF_1V8   = 4'd7;

endpackage

// File: rtl/vsw_target.sv
module vsw_target #(
    parameter int MV_W = 12
) (
    input  logic            to_1v8_i,
    input  logic [MV_W-1:0] slot_max_i,
    output logic [MV_W-1:0] min_o,
    output logic [MV_W-1:0] max_o,
    output logic            sel_o,
    output logic            skip_o
);
    import vsw_pkg::*;

    always_comb begin
        if (to_1v8_i) begin
            min_o = MV_W'(LOW_MIN_MV);
            max_o = MV_W'(LOW_MAX_MV);
        end else begin
            min_o = MV_W'(HIGH_MIN_MV);
            max_o = MV_W'(HIGH_MAX_MV);
        end
        sel_o  = to_1v8_i;
        skip_o = (min_o > slot_max_i);
    end

endmodule

// File: rtl/vsw_timer.sv
module vsw_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expired_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    AST_TMR_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TW'(1))); // R6

endmodule

// File: rtl/vsw_pad_cal.sv
module vsw_pad_cal (
    input  logic [31:0] cal_cur_i,
    input  logic [31:0] pad_cur_i,
    output logic [31:0] cal_new_o,
    output logic [31:0] pad_new_o
);
    import vsw_pkg::*;

    localparam logic [31:0] OFS_MASK = 32'((1 << OFS_W) - 1);
    localparam logic [31:0] REF_MASK = 32'((1 << REF_W) - 1);

    always_comb begin
        cal_new_o = cal_cur_i & ~(OFS_MASK << PD_LSB) & ~(OFS_MASK << PU_LSB);
        cal_new_o = cal_new_o | (32'(PD_OFS) << PD_LSB) | (32'(PU_OFS) << PU_LSB);
        cal_new_o[CAL_EN_BIT] = 1'b1;
        pad_new_o = (pad_cur_i & ~REF_MASK) | 32'(REF_1V8);
    end

endmodule

// File: rtl/vsw_seq.sv
module vsw_seq #(
    parameter int CLK_KHZ = 100000,
    parameter int MV_W    = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic            req_to_1v8_i,
    input  logic [MV_W-1:0] slot_max_mv_i,
    input  logic            reg_absent_i,
    input  logic            reg_ack_i,
    input  logic            reg_fail_i,
    input  logic [31:0]     cal_cur_i,
    input  logic [31:0]     pad_cur_i,
    output logic            card_clk_en_o,
    output logic            sel_1v8_o,
    output logic            reg_req_o,
    output logic [MV_W-1:0] reg_min_mv_o,
    output logic [MV_W-1:0] reg_max_mv_o,
    output logic            cal_we_o,
    output logic [31:0]     cal_wdata_o,
    output logic [31:0]     pad_wdata_o,
    output logic            done_o,
    output logic            err_o
);
    import vsw_pkg::*;

    localparam int LONG_CYC  = 10 * CLK_KHZ;
    localparam int SHORT_CYC = CLK_KHZ;
    localparam int TW        = $clog2(LONG_CYC + 1);

    typedef struct packed {
        vsw_state_e      st;
        logic            clk_en;
        logic            sel;
        logic            req;
        logic [MV_W-1:0] rmin;
        logic [MV_W-1:0] rmax;
        logic [MV_W-1:0] lmin;
        logic [MV_W-1:0] lmax;
        logic            lsel;
        logic            errf;
        logic            done;
        logic            err;
        logic            cal_we;
        logic [31:0]     cal_w;
        logic [31:0]     pad_w;
    } vsw_regs_t;

    vsw_regs_t       d, q;
    logic [MV_W-1:0] tgt_min, tgt_max;
    logic            tgt_sel, tgt_skip;
    logic            tmr_load, tmr_exp;
    logic [TW-1:0]   tmr_val;
    logic [31:0]     cal_new, pad_new;

    vsw_target #(.MV_W(MV_W)) u_target (
        .to_1v8_i   (req_to_1v8_i),
        .slot_max_i (slot_max_mv_i),
        .min_o      (tgt_min),
        .max_o      (tgt_max),
        .sel_o      (tgt_sel),
        .skip_o     (tgt_skip)
    );

    vsw_timer #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    vsw_pad_cal u_pad_cal (
        .cal_cur_i  (cal_cur_i),
        .pad_cur_i  (pad_cur_i),
        .cal_new_o  (cal_new),
        .pad_new_o  (pad_new)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        d.cal_we = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (tgt_skip) begin
                        d.done = 1'b1;
                    end else begin
                        d.st     = ST_GATE;
                        d.clk_en = 1'b0;
                        d.lmin   = tgt_min;
                        d.lmax   = tgt_max;
                        d.lsel   = tgt_sel;
                        d.errf   = 1'b0;
                    end
                end
            end
            ST_GATE: begin
                d.sel = q.lsel;
                d.st  = ST_RAIL;
            end
            ST_RAIL: begin
                if (reg_absent_i) begin
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LONG_CYC - 1);
                    d.st     = ST_WLONG;
                end else begin
                    d.req  = 1'b1;
                    d.rmin = q.lmin;
                    d.rmax = q.lmax;
                    d.st   = ST_ACK;
                end
            end
            ST_ACK: begin
                if (reg_ack_i) begin
                    d.req = 1'b0;
                    if (reg_fail_i) begin
                        d.errf = 1'b1;
                        d.st   = ST_FB_REQ;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LONG_CYC - 1);
                        d.st     = ST_WLONG;
                    end
                end
            end
            ST_FB_REQ: begin
                d.req  = 1'b1;
                d.rmin = MV_W'(HIGH_MIN_MV);
                d.rmax = MV_W'(HIGH_MAX_MV);
                d.st   = ST_FB_ACK;
            end
            ST_FB_ACK: begin
                if (reg_ack_i) begin
                    d.req    = 1'b0;
                    d.clk_en = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SHORT_CYC - 1);
                    d.st     = ST_WSHORT;
                end
            end
            ST_WLONG: begin
                if (tmr_exp) begin
                    d.clk_en = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SHORT_CYC - 1);
                    d.st     = ST_WSHORT;
                end
            end
            ST_WSHORT: begin
                if (tmr_exp) begin
                    if (q.lsel && !q.errf) begin
                        d.cal_we = 1'b1;
                        d.cal_w  = cal_new;
                        d.pad_w  = pad_new;
                        d.st     = ST_CAL;
                    end else begin
                        d.done = 1'b1;
                        d.err  = q.errf;
                        d.st   = ST_IDLE;
                    end
                end
            end
            ST_CAL: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.clk_en <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign card_clk_en_o = q.clk_en;
    assign sel_1v8_o     = q.sel;
    assign reg_req_o     = q.req;
    assign reg_min_mv_o  = q.rmin;
    assign reg_max_mv_o  = q.rmax;
    assign cal_we_o      = q.cal_we;
    assign cal_wdata_o   = q.cal_w;
    assign pad_wdata_o   = q.pad_w;
    assign done_o        = q.done;
    assign err_o         = q.err;

    AST_SEL_AFTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sel) |-> !$past(q.clk_en)); // R3
    AST_RAIL_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |-> !q.clk_en); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req && !reg_ack_i) |=> q.req); // R4
    AST_CAL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        q.cal_we |=> (q.done && !q.err)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R10

endmodule

// File: tb/tb_vsw_seq.sv
module tb_vsw_seq;
    localparam int CLK_KHZ = 3;
    localparam int MV_W    = 12;
    localparam int LONG    = 10 * CLK_KHZ;
    localparam int SHORT   = CLK_KHZ;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_to_1v8 = 1'b0;
    logic [MV_W-1:0] slot_max = '0;
    logic            reg_absent = 1'b0, reg_ack = 1'b0, reg_fail = 1'b0;
    logic [31:0]     cal_cur = '0, pad_cur = '0;
    logic            card_clk_en, sel_1v8, reg_req, cal_we, done, err;
    logic [MV_W-1:0] reg_min, reg_max;
    logic [31:0]     cal_wdata, pad_wdata;

    int tests = 0, fails = 0, cyc = 0;

    vsw_seq #(.CLK_KHZ(CLK_KHZ), .MV_W(MV_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_to_1v8_i(req_to_1v8),
        .slot_max_mv_i(slot_max), .reg_absent_i(reg_absent), .reg_ack_i(reg_ack),
        .reg_fail_i(reg_fail), .cal_cur_i(cal_cur), .pad_cur_i(pad_cur),
        .card_clk_en_o(card_clk_en), .sel_1v8_o(sel_1v8), .reg_req_o(reg_req),
        .reg_min_mv_o(reg_min), .reg_max_mv_o(reg_max), .cal_we_o(cal_we),
        .cal_wdata_o(cal_wdata), .pad_wdata_o(pad_wdata), .done_o(done), .err_o(err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor state, sampled at negedge
    logic fail_now = 1'b0;
    int   ack_cnt, wait_c, first_min, first_max, last_min, last_max;
    int   t_ack, t_clkon, t_done, t_cal, done_cnt, cal_cnt, viol;
    logic clk_low_seen, done_err;
    logic [31:0] cal_seen, pad_seen;

    task automatic mon_clear();
        ack_cnt = 0; wait_c = 0; first_min = 0; first_max = 0; last_min = 0; last_max = 0;
        t_ack = -1; t_clkon = -1; t_done = -1; t_cal = -1; done_cnt = 0; cal_cnt = 0;
        viol = 0; clk_low_seen = 1'b0; done_err = 1'b0; cal_seen = '0; pad_seen = '0;
    endtask

    initial mon_clear();

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_ack) begin
                reg_ack  <= 1'b0;
                reg_fail <= 1'b0;
                wait_c   = 0;
            end else if (reg_req) begin
                if (card_clk_en) viol++;
                wait_c++;
                if (wait_c == 2) begin
                    if (ack_cnt == 0) begin first_min = reg_min; first_max = reg_max; end
                    last_min = reg_min; last_max = reg_max;
                    reg_ack  <= 1'b1;
                    reg_fail <= fail_now;
                    fail_now = 1'b0;
                    ack_cnt++;
                    t_ack = cyc + 1;
                end
            end
            if (!card_clk_en) clk_low_seen = 1'b1;
            if (clk_low_seen && card_clk_en && t_clkon < 0) t_clkon = cyc;
            if (done) begin done_cnt++; t_done = cyc; done_err = err; end
            if (err && !done) viol++;
            if (cal_we) begin cal_cnt++; t_cal = cyc; cal_seen = cal_wdata; pad_seen = pad_wdata; end
        end
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic run_case(input int idx, input logic to18, input int slot,
                            input logic absent, input logic fail);
        int   t_acc, exp_min, exp_max, lim;
        logic skip, exp_err, sel_before, exp_sel, exp_cal;
        logic [31:0] e_cal, e_pad;
        @(negedge clk);
        mon_clear();
        cal_cur    = 32'hA5C3_0F96 ^ (32'(idx) * 32'h0103_0507);
        pad_cur    = 32'h5A3C_E1F8 ^ (32'(idx) * 32'h0709_0B0D);
        reg_absent = absent;
        fail_now   = fail;
        sel_before = sel_1v8;
        exp_min    = to18 ? 1800 : 2700;
        exp_max    = to18 ? 1800 : 3600;
        skip       = exp_min > slot;
        exp_err    = fail && !absent && !skip;
        exp_sel    = skip ? sel_before : to18;
        exp_cal    = to18 && !skip && !exp_err;
        e_cal = (cal_cur & ~(32'h7F << 8) & ~32'h7F) | (32'h70 << 8) | 32'h62 | (32'h1 << 29);
        e_pad = (pad_cur & ~32'hF) | 32'h7;
        req_valid  = 1'b1; req_to_1v8 = to18; slot_max = MV_W'(slot);
        t_acc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!skip) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_to_1v8 = !to18; slot_max = MV_W'(3600);  // R9 intruder
            @(negedge clk);
            req_valid = 1'b0;
        end
        lim = 0;
        while (done_cnt == 0 && lim < 400) begin @(negedge clk); lim++; end
        repeat (20) @(negedge clk);

        chk(done_cnt == 1, "R9/R10 done count", done_cnt, 1);
        chk(done_err == exp_err, "R5 err", done_err, exp_err);
        chk(sel_1v8 == exp_sel, "R1 select bit", sel_1v8, exp_sel);
        chk(card_clk_en == 1'b1, "R6 clock restored", card_clk_en, 1);
        chk(viol == 0, "R3/R10 ordering", viol, 0);
        chk(cal_cnt == (exp_cal ? 1 : 0), "R7 cal write count", cal_cnt, exp_cal);
        if (skip) begin
            chk(t_done == t_acc, "R2 skip done timing", t_done, t_acc);
            chk(!clk_low_seen && ack_cnt == 0, "R2 nothing changed", ack_cnt, 0);
        end else begin
            chk(clk_low_seen, "R3 clock gated", clk_low_seen, 1);
            if (absent) begin
                chk(ack_cnt == 0, "R4 absent no handshake", ack_cnt, 0);
                chk(t_clkon == t_acc + 2 + LONG, "R4 absent long wait", t_clkon, t_acc + 2 + LONG);
            end else begin
                chk(first_min == exp_min && first_max == exp_max, "R1 requested range",
                    first_min * 10000 + first_max, exp_min * 10000 + exp_max);
                if (fail) begin
                    chk(ack_cnt == 2, "R5 fallback request", ack_cnt, 2);
                    chk(last_min == 2700 && last_max == 3600, "R5 fallback range",
                        last_min * 10000 + last_max, 27003600);
                    chk(t_clkon == t_ack, "R5 clock on at fallback ack", t_clkon, t_ack);
                end else begin
                    chk(ack_cnt == 1, "R4 single handshake", ack_cnt, 1);
                    chk(t_clkon == t_ack + LONG, "R6 long wait", t_clkon, t_ack + LONG);
                end
            end
            chk(t_done == t_clkon + SHORT + (exp_cal ? 1 : 0), "R6 short wait",
                t_done, t_clkon + SHORT + (exp_cal ? 1 : 0));
            if (exp_cal) begin
                chk(t_cal == t_done - 1, "R7 cal before done", t_cal, t_done - 1);
                chk(cal_seen == e_cal, "R7 cal word", cal_seen, e_cal);
                chk(pad_seen == e_pad, "R8 pad word", pad_seen, e_pad);
            end
        end
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int idx = 0;
        int slots[4] = '{1700, 1800, 3300, 3600};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(card_clk_en == 1'b1 && sel_1v8 == 1'b0 && !reg_req && !done && !cal_we && !err,
            "R10 reset state", {card_clk_en, sel_1v8, reg_req, done, cal_we, err}, 6'b100000);
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 2; a++)
                for (int f = 0; f < 2; f++)
                    for (int v = 1; v >= 0; v--) begin
                        run_case(idx, v[0], slots[s], a[0], f[0]);
                        idx++;
                    end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule